// File: doc/BRIEF.md
# Indirect Register Access Engine

The engine reaches a hidden space of 16-bit registers that is only visible through a small mailbox on a 32-bit register bus. A client asks for one read or one write with an address and, for writes, a data word. The engine then drives the mailbox accesses itself. For a write it loads an encoded address, then the data, then a command word. For a read it loads the encoded address and a command word, then polls a read-back word until that word reports ready.

A read ends with the 16-bit value, or with an all-ones value and an error or timeout flag. The client raises `req` for one cycle while the engine is idle. It then waits for the one-cycle `done` pulse. The result and flags stay valid until the next request is taken. The bus side carries one access at a time, and each access is held until the slave raises `bus_ready`. The four mailbox offsets, the poll limit and the address tag are parameters.

Top module: `indirect_reg_engine`

## Requirements
- R1: After reset the engine is idle. `busy`, `done`, `bus_wr`, `bus_rd`, `result`, `timeout` and `error` are all 0, and no bus access happens while `req` stays low.
- R2: The first access of every request is a write to the control offset (default 0x00). Its data is the client address shifted right by one, plus 0x30000.
- R3: A write request makes exactly three bus writes in this order: the control offset, then the write-data offset (default 0x04) carrying the client data zero-extended to 32 bits, then the command offset (default 0x08) carrying 0x1. It makes no reads, and `done` follows acceptance of the command write.
- R4: A read request makes a control write, then a command write carrying 0x2, then bus reads of the read-data offset (default 0x0C) only.
- R5: Polling repeats while bit 18 of the read word is 0. When bit 18 is 1 and bits 17:16 equal 01, the result is bits 15:0 and both flags are 0.
- R6: When bit 18 is 1 and bits 17:16 are 00, 10 or 11, the result is 0xFFFF and `error` is 1, with `timeout` at 0.
- R7: When 32 reads pass without bit 18 set, polling stops after exactly 32 reads. The result is then 0xFFFF with `timeout` at 1 and `error` at 0.
- R8: Each access keeps its strobe, address and data stable until `bus_ready` is sampled high, and the next access starts in the following cycle. A request making A accesses with L wait cycles each raises `done` A*(1+L) cycles after the cycle that took `req`.
- R9: `done` lasts one cycle. `result`, `timeout` and `error` hold until the next accepted request, and a `req` raised while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Client request, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Hidden register address |
| req_wdata | input | REG_W | Data for a write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | REG_W | Read value, or all ones on failure |
| timeout | output | 1 | The poll limit was reached |
| error | output | 1 | Ready was seen with a status other than OK |
| bus_wr | output | 1 | Bus write strobe |
| bus_rd | output | 1 | Bus read strobe |
| bus_addr | output | BUS_AW | Mailbox offset |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ready |
| bus_ready | input | 1 | Slave accepts the current access |

## Verification
`done` is due exactly A*(1+L) cycles after the edge that takes `req`, where A is the access count and L is the slave's wait count. The bench counts falling edges from the request and compares that count to the formula. The slave model changes `bus_ready` and `bus_rdata` only on falling edges. It logs every access at the falling edge before the rising edge that accepts it, so the log and every output check are read half a cycle away from the edge that changes them. Flags and result are read at the falling edge where `done` is first high, and again three cycles later to confirm they hold.

// File: rtl/indirect_reg_engine.sv
module indirect_reg_engine #(
  parameter int ADDR_W = 16,
  parameter int REG_W = 16,
  parameter int DATA_W = 32,
  parameter int BUS_AW = 8,
  parameter logic [BUS_AW-1:0] OFS_CTRL = 'h00,
  parameter logic [BUS_AW-1:0] OFS_WDATA = 'h04,
  parameter logic [BUS_AW-1:0] OFS_CMD = 'h08,
  parameter logic [BUS_AW-1:0] OFS_RDATA = 'h0C,
  parameter logic [DATA_W-1:0] ADDR_TAG = 'h30000,
  parameter int POLL_MAX = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              busy,
  output logic              done,
  output logic [REG_W-1:0]  result,
  output logic              timeout,
  output logic              error,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready
);
  localparam int CNT_W = $clog2(POLL_MAX + 1);
  localparam int RDY_BIT = 18;
  localparam int STAT_LO = 16;
  localparam logic [1:0] STAT_OK = 2'b01;
  localparam logic [DATA_W-1:0] CMD_WR = 'h1;
  localparam logic [DATA_W-1:0] CMD_RD = 'h2;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_WDAT, S_CMD, S_POLL} state_t;

  state_t            st;
  logic              is_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  wdata_q;
  logic [CNT_W-1:0]  poll_cnt;

  wire acc = (bus_wr | bus_rd) & bus_ready;
  wire rd_ready = bus_rdata[RDY_BIT];
  wire [1:0] rd_stat = bus_rdata[STAT_LO+1:STAT_LO];

  assign busy   = (st != S_IDLE);
  assign bus_wr = (st == S_CTRL) | (st == S_WDAT) | (st == S_CMD);
  assign bus_rd = (st == S_POLL);

  always_comb begin
    bus_addr  = OFS_RDATA;
    bus_wdata = '0;
    case (st)
      S_CTRL: begin bus_addr = OFS_CTRL;  bus_wdata = ADDR_TAG + DATA_W'(addr_q >> 1); end
      S_WDAT: begin bus_addr = OFS_WDATA; bus_wdata = DATA_W'(wdata_q); end
      S_CMD:  begin bus_addr = OFS_CMD;   bus_wdata = is_wr ? CMD_WR : CMD_RD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      is_wr <= 1'b0;
      addr_q <= '0;
      wdata_q <= '0;
      poll_cnt <= '0;
      done <= 1'b0;
      result <= '0;
      timeout <= 1'b0;
      error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          is_wr <= req_write;
          addr_q <= req_addr;
          wdata_q <= req_wdata;
          result <= '0;
          timeout <= 1'b0;
          error <= 1'b0;
          st <= S_CTRL;
        end
        S_CTRL: if (acc) st <= is_wr ? S_WDAT : S_CMD;
        S_WDAT: if (acc) st <= S_CMD;
        S_CMD: if (acc) begin
          if (is_wr) begin
            st <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_POLL;
            poll_cnt <= '0;
          end
        end
        S_POLL: if (acc) begin
          if (rd_ready) begin
            st <= S_IDLE;
            done <= 1'b1;
            if (rd_stat == STAT_OK) result <= bus_rdata[REG_W-1:0];
            else begin
              result <= '1;
              error <= 1'b1;
            end
          end else if (poll_cnt == CNT_W'(POLL_MAX - 1)) begin
            st <= S_IDLE;
            done <= 1'b1;
            result <= '1;
            timeout <= 1'b1;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_accept_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> (bus_wr && bus_addr == OFS_CTRL));
  assert_error_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (result == '1 && !timeout));
  assert_timeout_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> (result == '1 && !error));
  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (poll_cnt < CNT_W'(POLL_MAX)));
  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_ready) |=>
      (bus_wr == $past(bus_wr) && bus_rd == $past(bus_rd) && $stable(bus_addr) && $stable(bus_wdata)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> ($stable(result) && $stable(timeout) && $stable(error)));
endmodule

// File: tb/indirect_reg_engine_test.sv
module indirect_reg_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam int V_WR    [NV] = '{1, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_ADDR  [NV] = '{'h0A24, 'h0001, 'h1000, 'hFFFF, 'h0246, 'h0010, 'h0020, 'h0030, 'h8000};
  localparam int V_WDAT  [NV] = '{'h5A5A, 'hFFFF, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_LAT   [NV] = '{0, 2, 0, 1, 0, 1, 0, 2, 0};
  localparam int V_POLLS [NV] = '{0, 0, 0, 5, 31, 2, 0, 0, 32};
  localparam int V_STAT  [NV] = '{1, 1, 1, 1, 1, 0, 2, 3, 1};
  localparam int V_RDAT  [NV] = '{0, 0, 'h1234, 'hABCD, 'h0042, 'h7777, 'h1111, 'h2222, 'h3333};
  localparam int V_EXP   [NV] = '{0, 0, 'h1234, 'hABCD, 'h0042, 'hFFFF, 'hFFFF, 'hFFFF, 'hFFFF};
  localparam int V_TO    [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam int V_ER    [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0};

  logic clk = 0, rst_n = 0, req = 0, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic busy, done, timeout, error, bus_wr, bus_rd;
  logic [15:0] result;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = 0;
  logic bus_ready = 0;

  indirect_reg_engine uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .result(result), .timeout(timeout),
    .error(error), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int lat = 0, nr_polls = 0, rd_base = 0, rd_total = 0, wcnt = 0, lg_n = 0, hold_viol = 0;
  logic [1:0] fin_stat = 0;
  logic [15:0] fin_data = 0;
  logic [7:0] lg_addr [256];
  logic [31:0] lg_data [256];
  logic lg_wr [256];
  logic pq = 0, pw = 0, pr = 0;
  logic [7:0] pa = 0;
  logic [31:0] pd = 0;

  always @(negedge clk) begin
    if (pq && !(bus_wr == pw && bus_rd == pr && bus_addr == pa && bus_wdata == pd)) hold_viol <= hold_viol + 1;
    pq <= (bus_wr || bus_rd) && (wcnt != lat);
    pw <= bus_wr; pr <= bus_rd; pa <= bus_addr; pd <= bus_wdata;
    bus_ready <= 1'b0;
    if (bus_wr || bus_rd) begin
      if (wcnt == lat) begin
        bus_ready <= 1'b1;
        wcnt <= 0;
        lg_addr[lg_n % 256] <= bus_addr;
        lg_data[lg_n % 256] <= bus_wdata;
        lg_wr[lg_n % 256] <= bus_wr;
        lg_n <= lg_n + 1;
        if (bus_rd) begin
          bus_rdata <= (rd_total - rd_base < nr_polls) ? 32'h0003_BEEF : {13'd0, 1'b1, fin_stat, fin_data};
          rd_total <= rd_total + 1;
        end
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    summary();
  end

  task automatic start(input int wr, input int addr, input int wd);
    @(negedge clk);
    rd_base = rd_total;
    req = 1; req_write = wr[0]; req_addr = addr[15:0]; req_wdata = wd[15:0];
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    int base, cyc, nacc, nreads;
    logic [31:0] enc;
    logic [15:0] r_keep;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_wr && !bus_rd, "R1", "idle strobes in reset", {busy, done, bus_wr, bus_rd}, 0);
    chk(result == 0 && !timeout && !error, "R1", "result/flags in reset", {result, timeout, error}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(lg_n == 0 && !busy, "R1", "no access with req low", lg_n, 0);

    for (int v = 0; v < NV; v++) begin
      lat = V_LAT[v]; nr_polls = V_POLLS[v]; fin_stat = V_STAT[v][1:0]; fin_data = V_RDAT[v][15:0];
      base = lg_n;
      enc = 32'h30000 + 32'(V_ADDR[v][15:0] >> 1);
      nreads = V_WR[v] ? 0 : ((nr_polls >= 32) ? 32 : nr_polls + 1);
      nacc = V_WR[v] ? 3 : 2 + nreads;
      start(V_WR[v], V_ADDR[v], V_WDAT[v]);
      cyc = 1;
      while (!done && cyc < 400) begin @(negedge clk); cyc++; end
      chk(cyc == nacc * (1 + lat) + 1, "R8", $sformatf("v%0d done latency", v), cyc, nacc * (1 + lat) + 1);
      chk(result == V_EXP[v][15:0], V_WR[v] ? "R3" : (V_TO[v] ? "R7" : (V_ER[v] ? "R6" : "R5")),
          $sformatf("v%0d result", v), result, V_EXP[v]);
      chk(timeout == V_TO[v][0] && error == V_ER[v][0], V_TO[v] ? "R7" : "R6",
          $sformatf("v%0d flags to/err", v), {timeout, error}, {V_TO[v][0], V_ER[v][0]});
      chk(lg_n - base == nacc, V_WR[v] ? "R3" : "R4", $sformatf("v%0d access count", v), lg_n - base, nacc);
      chk(lg_wr[base % 256] && lg_addr[base % 256] == 8'h00 && lg_data[base % 256] == enc, "R2",
          $sformatf("v%0d control word", v), lg_data[base % 256], enc);
      if (V_WR[v]) begin
        chk(lg_wr[(base + 1) % 256] && lg_addr[(base + 1) % 256] == 8'h04 && lg_data[(base + 1) % 256] == 32'(V_WDAT[v]),
            "R3", $sformatf("v%0d data write", v), lg_data[(base + 1) % 256], V_WDAT[v]);
        chk(lg_wr[(base + 2) % 256] && lg_addr[(base + 2) % 256] == 8'h08 && lg_data[(base + 2) % 256] == 1,
            "R3", $sformatf("v%0d command write", v), lg_data[(base + 2) % 256], 1);
      end else begin
        chk(lg_wr[(base + 1) % 256] && lg_addr[(base + 1) % 256] == 8'h08 && lg_data[(base + 1) % 256] == 2,
            "R4", $sformatf("v%0d command write", v), lg_data[(base + 1) % 256], 2);
        for (int k = 2; k < nacc; k++)
          if (lg_wr[(base + k) % 256] || lg_addr[(base + k) % 256] != 8'h0C)
            chk(0, "R4", $sformatf("v%0d poll access %0d", v, k), lg_addr[(base + k) % 256], 8'h0C);
        checks++;
      end
      r_keep = result;
      base = lg_n;
      repeat (3) @(negedge clk);
      chk(!done && result == r_keep && timeout == V_TO[v][0] && error == V_ER[v][0] && lg_n == base, "R9",
          $sformatf("v%0d pulse/hold", v), {done, result}, {1'b0, r_keep});
    end
    chk(hold_viol == 0, "R8", "access stable while waiting", hold_viol, 0);

    lat = 1; nr_polls = 3; fin_stat = 2'b01; fin_data = 16'h5AA5;
    base = lg_n;
    start(0, 'h0100, 0);
    @(negedge clk);
    req = 1; req_write = 1; req_addr = 16'h0200; req_wdata = 16'h9999;
    @(negedge clk);
    req = 0;
    cyc = 0;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    repeat (6) @(negedge clk);
    chk(lg_n - base == 6 && !busy, "R9", "req while busy ignored", lg_n - base, 6);
    chk(result == 16'h5AA5 && !error && !timeout, "R9", "busy-ignore result", result, 16'h5AA5);
    summary();
  end
endmodule